// File: doc/BRIEF.md
# Chip-Select-Gated Registered Address Buffer

This block is a bank of clocked registers that sits between a memory controller and the memory devices on a module. On each rising clock edge it captures the command/address bus and drives registered copies outward. The data bus is captured only when at least one of two active-low chip-select inputs is low. Otherwise the data outputs hold their last values. The registered chip-select, on-die-termination and clock-enable outputs are refreshed on every edge, whatever the chip-selects are.

A static configuration pin picks one of two layouts. In wide mode each of the `IN_W` input bits drives one output. In split mode each of the lower `NARROW` input bits drives two identical output copies. The output bus is as wide as the larger of the two layouts. The configuration is latched only while reset is active. An active-low reset clears every output at once. Its release passes through a two-stage synchronizer, so the first capture falls on a clean clock edge.

The block moves data at a fixed cycle with no flow control. There is no valid/ready handshake, and the controller cannot be back-pressured. All pins are plain control or data levels.

Top module: `cs_addr_buf`

## Requirements
- R1: Driving `rst_n` low clears `q_data`, `q_cs`, `q_odt` and `q_cke` to zero at once, without waiting for a clock edge.
- R2: While `rst_n` is low, all outputs stay zero even when the data, chip-select, termination and clock-enable inputs are unknown.
- R3: Out of reset, with `cs0_n` low, `q_data` takes the mapped `din` on the rising edge, whatever `cs1_n` is.
- R4: Out of reset, with `cs0_n` high and `cs1_n` low, `q_data` still takes the mapped `din` on the rising edge.
- R5: Out of reset, with both `cs0_n` and `cs1_n` high, `q_data` keeps its previous value across the edge.
- R6: `q_cs` takes the value of `cs0_n` on every rising edge out of reset, independent of `cs1_n`.
- R7: `q_odt` and `q_cke` take `odt_in` and `cke_in` on every rising edge out of reset, whatever the chip-selects are.
- R8: Between rising edges, no output changes when the inputs change.
- R9: In wide mode (`cfg_split` = 0 during reset), `q_data[i]` = `din[i]` for i < `IN_W`, and the output bits from `IN_W` up to the top are zero.
- R10: In split mode (`cfg_split` = 1 during reset), `q_data[i]` and `q_data[i+NARROW]` both equal `din[i]` for i < `NARROW`. The input bits from `NARROW` upward are ignored, and the two copies are always identical.
- R11: `cfg_split` is sampled only while reset is active. Changing it during operation has no effect on the mapping.
- R12: After `rst_n` rises between edges, the outputs stay zero through the next two rising edges. The first capture happens on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous assertion, synchronized release |
| cfg_split | input | 1 | Layout select, sampled during reset: 0 wide, 1 split |
| din | input | IN_W | Command/address input bus |
| cs0_n | input | 1 | Primary chip select, active low |
| cs1_n | input | 1 | Secondary chip select, active low |
| odt_in | input | 1 | Termination control input |
| cke_in | input | 1 | Clock-enable input |
| q_data | output | max(IN_W, 2*NARROW) | Registered data outputs |
| q_cs | output | 1 | Registered primary chip select |
| q_odt | output | 1 | Registered termination control |
| q_cke | output | 1 | Registered clock enable |

## Verification
The bench builds the block with its default parameters, `IN_W` = 25 and `NARROW` = 14. Because 2*`NARROW` = 28 exceeds `IN_W`, the output bus has three bits that wide mode must hold at zero. In split mode the inputs 14 to 24 are the ignored bits. Both of these are therefore visible at the ports. The same stimulus table runs in both layouts, so each chip-select combination is checked against both mappings.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam int unsigned CAB_IN_W   = 25;
  localparam int unsigned CAB_NARROW = 14;

  typedef enum logic {
    CAB_WIDE  = 1'b0,
    CAB_SPLIT = 1'b1
  } cab_mode_e;
endpackage

// File: rtl/cab_rst_sync.sv
module cab_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_ok = chain[STAGES-1];
endmodule

// File: rtl/cab_fanout.sv
module cab_fanout
  import cab_pkg::*;
#(
  parameter int unsigned IN_W   = CAB_IN_W,
  parameter int unsigned NARROW = CAB_NARROW,
  parameter int unsigned OUT_W  = (IN_W > 2*NARROW) ? IN_W : 2*NARROW
) (
  input  cab_mode_e        mode,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] fan
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    logic wide_b, split_b;
    if (i < IN_W) begin : g_w
      assign wide_b = din[i];
    end else begin : g_wz
      assign wide_b = 1'b0;
    end
    if (i < NARROW) begin : g_lo
      assign split_b = din[i];
    end else if (i < 2*NARROW) begin : g_hi
      assign split_b = din[i-NARROW];
    end else begin : g_sz
      assign split_b = 1'b0;
    end
    assign fan[i] = (mode == CAB_SPLIT) ? split_b : wide_b;
  end
endmodule

// File: rtl/cs_addr_buf.sv
module cs_addr_buf
  import cab_pkg::*;
#(
  parameter int unsigned IN_W   = CAB_IN_W,
  parameter int unsigned NARROW = CAB_NARROW,
  localparam int unsigned OUT_W = (IN_W > 2*NARROW) ? IN_W : 2*NARROW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_split,
  input  logic [IN_W-1:0]  din,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic             odt_in,
  input  logic             cke_in,
  output logic [OUT_W-1:0] q_data,
  output logic             q_cs,
  output logic             q_odt,
  output logic             q_cke
);
  logic             rst_ok;
  cab_mode_e        mode_q;
  logic [OUT_W-1:0] fan;
  logic             capture;

  cab_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  // Layout is latched only while the block is held in reset.
  always_ff @(posedge clk) begin
    if (!rst_ok) mode_q <= cab_mode_e'(cfg_split);
  end

  cab_fanout #(.IN_W(IN_W), .NARROW(NARROW), .OUT_W(OUT_W)) u_fan (
    .mode (mode_q),
    .din  (din),
    .fan  (fan)
  );

  assign capture = ~(cs0_n & cs1_n);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      q_data <= '0;
    else if (capture) q_data <= fan;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      q_cs  <= 1'b0;
      q_odt <= 1'b0;
      q_cke <= 1'b0;
    end else begin
      q_cs  <= cs0_n;
      q_odt <= odt_in;
      q_cke <= cke_in;
    end
  end
endmodule

// File: rtl/cab_checker.sv
module cab_checker #(
  parameter int unsigned NARROW = 14,
  parameter int unsigned OUT_W  = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic             mode_q,
  input logic             cs0_n,
  input logic             cs1_n,
  input logic             odt_in,
  input logic             cke_in,
  input logic [OUT_W-1:0] q_data,
  input logic             q_cs,
  input logic             q_odt,
  input logic             q_cke
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (q_data == '0 && !q_cs && !q_odt && !q_cke)); // R1
  AST_HOLD_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) (rst_ok && cs0_n && cs1_n) |=> $stable(q_data)); // R5
  AST_CS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) rst_ok |=> (q_cs == $past(cs0_n))); // R6
  AST_CTRL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) rst_ok |=> (q_odt == $past(odt_in) && q_cke == $past(cke_in))); // R7
  AST_SPLIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n) (rst_ok && mode_q) |-> (q_data[NARROW-1:0] == q_data[2*NARROW-1:NARROW])); // R10
  AST_MODE_STATIC: assert property (@(posedge clk) disable iff (!rst_n) rst_ok |=> $stable(mode_q)); // R11
  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !rst_ok |=> (q_data == '0 && !q_cs)); // R12
endmodule

bind cs_addr_buf cab_checker #(.NARROW(NARROW), .OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_ok (rst_ok),
  .mode_q (mode_q),
  .cs0_n  (cs0_n),
  .cs1_n  (cs1_n),
  .odt_in (odt_in),
  .cke_in (cke_in),
  .q_data (q_data),
  .q_cs   (q_cs),
  .q_odt  (q_odt),
  .q_cke  (q_cke)
);

// File: tb/sim_cs_addr_buf.sv
module sim_cs_addr_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_split = 1'b0;
  logic [24:0] din = '0;
  logic        cs0_n = 1'b1, cs1_n = 1'b1, odt_in = 1'b0, cke_in = 1'b0;
  logic [27:0] q_data;
  logic        q_cs, q_odt, q_cke;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [27:0] exp_q = '0;

  always #10 clk = ~clk; // 50 MHz

  cs_addr_buf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .din(din),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .odt_in(odt_in), .cke_in(cke_in),
    .q_data(q_data), .q_cs(q_cs), .q_odt(q_odt), .q_cke(q_cke)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        c0, c1, odt, cke;
    logic [24:0] d;
    logic        cap;
  } vec_t;

  // Stimulus and expected capture (1) or hold (0); rows tagged R3, R4, R5, R6, R7.
  localparam vec_t VECS [10] = '{
    '{4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 25'h1ABCDEF, 1'b1},
    '{4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 25'h0123456, 1'b0},
    '{4'd4, 1'b1, 1'b0, 1'b1, 1'b1, 25'h0F0F0F0, 1'b1},
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFFFFF, 1'b1},
    '{4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 25'h0000000, 1'b0},
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 25'h1555555, 1'b0},
    '{4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 25'h0AAAAAA, 1'b1},
    '{4'd7, 1'b1, 1'b1, 1'b1, 1'b1, 25'h1000001, 1'b0},
    '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 25'h0000001, 1'b1},
    '{4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 25'h1C00000, 1'b1}
  };

  function automatic logic [27:0] map_bits(bit split, logic [24:0] d);
    return split ? {d[13:0], d[13:0]} : {3'b000, d};
  endfunction

  task automatic check(string tag, logic [30:0] act, logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] outs();
    return {q_data, q_cs, q_odt, q_cke};
  endfunction

  task automatic run_table(bit split);
    for (int k = 0; k < 10; k++) begin
      cs0_n = VECS[k].c0; cs1_n = VECS[k].c1;
      odt_in = VECS[k].odt; cke_in = VECS[k].cke; din = VECS[k].d;
      @(posedge clk);
      @(negedge clk);
      if (VECS[k].cap) exp_q = map_bits(split, VECS[k].d);
      check($sformatf("R%0d %s row %0d", VECS[k].rq, split ? "split R10" : "wide R9", k),
            outs(), {exp_q, VECS[k].c0, VECS[k].odt, VECS[k].cke});
    end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    // R2: unknown inputs under reset
    din = 'x; cs0_n = 1'bx; cs1_n = 1'bx; odt_in = 1'bx; cke_in = 1'bx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 outputs low under reset", outs(), '0);

    // R12: synchronized release
    rst_n = 1'b1; cs0_n = 1'b0; cs1_n = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
    din = 25'h1234567;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R12 still low after two edges", outs(), '0);
    @(posedge clk); @(negedge clk);
    exp_q = map_bits(0, 25'h1234567);
    check("R12 first capture third edge", outs(), {exp_q, 1'b0, 1'b1, 1'b1});

    run_table(0);

    // R8: no change between edges
    din = 25'h0777777; cs0_n = 1'b1; cs1_n = 1'b0; odt_in = 1'b0; cke_in = 1'b0;
    #5;
    check("R8 stable mid-cycle", outs(), {exp_q, 1'b0, 1'b1, 1'b0});
    @(posedge clk); @(negedge clk);
    exp_q = map_bits(0, 25'h0777777);
    check("R8 R4 capture after edge", outs(), {exp_q, 1'b1, 1'b0, 1'b0});

    // R11: cfg change in operation is ignored
    cfg_split = 1'b1; din = 25'h1FC0123; cs0_n = 1'b0;
    @(posedge clk); @(negedge clk);
    exp_q = map_bits(0, 25'h1FC0123);
    check("R11 mapping stays wide", outs(), {exp_q, 1'b0, 1'b0, 1'b0});

    // R1: asynchronous reset mid-cycle
    #3 rst_n = 1'b0;
    #1 check("R1 async clear", outs(), '0);
    exp_q = '0;

    // split mode: cfg_split high during reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    run_table(1);

    // R10: upper inputs ignored in split mode
    din = 25'h1FFC000; cs0_n = 1'b0; odt_in = 1'b0; cke_in = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 upper inputs ignored", outs(), {28'h0, 1'b0, 1'b0, 1'b0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule